// File: doc/BRIEF.md
# In-Epoch Butterfly Address Generator

This block sits beside a four-way radix-2 butterfly engine that computes a P-point transform in place, held in a P-entry register file. Each request is a descriptor: an operation code, the group size written as log2 P (3 to 10), a flag that makes the other field size Q equal to P/2 instead of P, a module index i, a stage index j and a group index g. For a butterfly step the block returns the eight register-file addresses the engine reads and writes back, and the four twiddle ROM addresses it needs. Between stages the data is not moved. Instead, the register address of each position is re-derived through a chain of adjacent-bit exchanges.

The four memory operations produce the main-memory addresses used to fill the register file at the start of an epoch and to empty it at the end. The memory index has n = p + q bits, made of a high field and a low field. The outputs fold in the bit reversal that the butterfly chain leaves behind, and the exchange of the two fields between the two epochs. All outputs are registered. Results appear one cycle after a valid request, and a descriptor out of range raises an error flag.

Top module: `fftag_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_vld` and `out_err` are low.
- R2: Operation code 0 (butterfly): lane s (0..7) of module i serves position k = 8(i-1)+s. Lane s sits in `out_reg` bits [10s+9:10s]. In stage 1 the lane address is k. In stage j it is the stage j-1 address with p-bit positions j-1 and j exchanged, counting positions from the most significant bit starting at 1, which means bit indices p-j+1 and p-j.
- R3: For a butterfly, twiddle lane c (0..3) sits in `out_tw` bits [9c+8:9c]. Its value is floor(t / S) * S, with t = 4(i-1)+c and S = P / 2^j.
- R4: Every twiddle address lies in 0..P/2-1. For P = 32 and stage 2, modules 1 to 4 receive (0,0,0,0), (0,0,0,0), (8,8,8,8) and (8,8,8,8).
- R5: Loads use code 1 (epoch 0) and code 3 (epoch 1). The register lane address is k. Lane s sits in `out_mem` bits [20s+19:20s]. Code 1 gives the memory address g*P + k. Code 3 gives rev_p(k)*Q + g, where rev_w reverses the low w bits.
- R6: Stores use code 2 (epoch 0) and code 4 (epoch 1). The register lane address is the position's stage-p address from R2. Code 2 gives the memory address g*P + rev_p(k). Code 4 gives rev_p(k)*Q + rev_q(g).
- R7: With `in_q_short` low, Q = P. With it high, Q = P/2. Q sets the legal range of g and the field widths in R5 and R6.
- R8: The block raises `out_err` and drives all address outputs to zero in any of these cases: log2 P outside 3..10, i outside 1..P/8, an operation code above 4, a butterfly with j outside 1..log2 P, or a memory operation with g >= Q.
- R9: `out_vld` equals `in_vld` of the previous cycle. Addresses and `out_err` belong to that request. Outputs not used by the operation are zero, including twiddles on memory operations and memory addresses on butterflies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Descriptor valid |
| in_op | input | 3 | Operation code (0 butterfly, 1..4 memory) |
| in_log2p | input | 4 | log2 of group size P |
| in_q_short | input | 1 | High: Q = P/2; low: Q = P |
| in_mod | input | 8 | Module index i, from 1 |
| in_stage | input | 4 | Stage index j, from 1 |
| in_grp | input | 10 | Group index g |
| out_vld | output | 1 | Result valid |
| out_err | output | 1 | Descriptor out of range |
| out_reg | output | 80 | Eight register-file lane addresses |
| out_tw | output | 36 | Four twiddle ROM addresses |
| out_mem | output | 160 | Eight memory lane addresses |

## Verification
A wrong bit-exchange chain shows up on the very next valid cycle as two lanes that address the wrong registers. The bench sweeps every module and stage for P from 8 to 64, so a misplaced swap index cannot hide in stages that are rarely used. A wrong twiddle stride or a wrong field reversal shows up in the same cycle on `out_tw` or `out_mem`. A stale pipeline register shows up as an `out_vld` or `out_err` that does not match the request of the previous cycle.

// File: rtl/fftag_pkg.sv
package fftag_pkg;
    localparam int LOGP_MAX = 10;
    localparam int LOGP_MIN = 3;
    localparam int AW       = LOGP_MAX;
    localparam int TW       = LOGP_MAX - 1;
    localparam int MW       = 2 * LOGP_MAX;
    localparam int LANES    = 8;
    localparam int TLANES   = 4;
    localparam int MOD_W    = LOGP_MAX - 2;
    localparam int STG_W    = $clog2(LOGP_MAX + 1);
    localparam int LP_W     = STG_W;

    typedef enum logic [2:0] {
        OP_BFLY = 3'd0,
        OP_LD0  = 3'd1,
        OP_ST0  = 3'd2,
        OP_LD1  = 3'd3,
        OP_ST1  = 3'd4
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LP_W-1:0]  log2p;
        logic             q_short;
        logic [MOD_W-1:0] mod;
        logic [STG_W-1:0] stage;
        logic [AW-1:0]    grp;
    } desc_t;

    function automatic logic [AW-1:0] bit_rev(input logic [AW-1:0] v, input int w);
        logic [AW-1:0] r;
        r = '0;
        for (int b = 0; b < AW; b++)
            if (b < w) r[b] = v[w-1-b];
        return r;
    endfunction

    function automatic logic [AW-1:0] stage_swap(input logic [AW-1:0] k, input int p, input int j);
        logic [AW-1:0] a;
        logic          tmp;
        a = k;
        for (int t = 2; t <= LOGP_MAX; t++) begin
            if (t <= j && t <= p) begin
                tmp        = a[p-t+1];
                a[p-t+1]   = a[p-t];
                a[p-t]     = tmp;
            end
        end
        return a;
    endfunction
endpackage

// File: rtl/fftag_check.sv
module fftag_check
    import fftag_pkg::*;
(
    input  desc_t d,
    output logic  err
);
    int p, q, mods;
    logic ok_p;

    always_comb begin
        p    = int'(d.log2p);
        ok_p = (p >= LOGP_MIN) && (p <= LOGP_MAX);
        q    = p - int'(d.q_short);
        mods = ok_p ? (1 << (p - 3)) : 0;
        err  = 1'b0;
        if (!ok_p)                                   err = 1'b1;
        else if (d.mod == '0 || int'(d.mod) > mods)  err = 1'b1;
        else begin
            case (d.op)
                OP_BFLY: if (d.stage == '0 || int'(d.stage) > p) err = 1'b1;
                OP_LD0, OP_ST0, OP_LD1, OP_ST1:
                         if (int'(d.grp) >= (1 << q)) err = 1'b1;
                default: err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/fftag_lanes.sv
module fftag_lanes
    import fftag_pkg::*;
(
    input  desc_t                  d,
    output logic [LANES*AW-1:0]    reg_addr,
    output logic [LANES*MW-1:0]    mem_addr
);
    logic [MOD_W-1:0] mod_m1;
    int p, q;
    assign mod_m1 = d.mod - MOD_W'(1);
    assign p      = int'(d.log2p);
    assign q      = int'(d.log2p) - int'(d.q_short);

    for (genvar s = 0; s < LANES; s++) begin : g_lane
        logic [AW-1:0] k, kr;
        logic [MW-1:0] kw, krw, gw, grw;
        always_comb begin
            k   = AW'({mod_m1, 3'(s)});
            kr  = bit_rev(k, p);
            kw  = MW'(k);
            krw = MW'(kr);
            gw  = MW'(d.grp);
            grw = MW'(bit_rev(d.grp, q));
            case (d.op)
                OP_BFLY: reg_addr[s*AW +: AW] = stage_swap(k, p, int'(d.stage));
                OP_ST0, OP_ST1: reg_addr[s*AW +: AW] = stage_swap(k, p, p);
                OP_LD0, OP_LD1: reg_addr[s*AW +: AW] = k;
                default: reg_addr[s*AW +: AW] = '0;
            endcase
            case (d.op)
                OP_LD0:  mem_addr[s*MW +: MW] = (gw << p) | kw;
                OP_ST0:  mem_addr[s*MW +: MW] = (gw << p) | krw;
                OP_LD1:  mem_addr[s*MW +: MW] = (krw << q) | gw;
                OP_ST1:  mem_addr[s*MW +: MW] = (krw << q) | grw;
                default: mem_addr[s*MW +: MW] = '0;
            endcase
        end
    end
endmodule

// File: rtl/fftag_twiddle.sv
module fftag_twiddle
    import fftag_pkg::*;
(
    input  desc_t                  d,
    output logic [TLANES*TW-1:0]   tw_addr
);
    logic [MOD_W-1:0] mod_m1;
    int sh;
    assign mod_m1 = d.mod - MOD_W'(1);
    assign sh     = int'(d.log2p) - int'(d.stage);

    for (genvar c = 0; c < TLANES; c++) begin : g_tw
        logic [TW-1:0] t;
        always_comb begin
            t = TW'({mod_m1, 2'(c)});
            if (d.op == OP_BFLY && sh >= 0)
                tw_addr[c*TW +: TW] = (t >> sh) << sh;
            else
                tw_addr[c*TW +: TW] = '0;
        end
    end
endmodule

// File: rtl/fftag_top.sv
module fftag_top
    import fftag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic [2:0]            in_op,
    input  logic [LP_W-1:0]       in_log2p,
    input  logic                  in_q_short,
    input  logic [MOD_W-1:0]      in_mod,
    input  logic [STG_W-1:0]      in_stage,
    input  logic [AW-1:0]         in_grp,
    output logic                  out_vld,
    output logic                  out_err,
    output logic [LANES*AW-1:0]   out_reg,
    output logic [TLANES*TW-1:0]  out_tw,
    output logic [LANES*MW-1:0]   out_mem
);
    desc_t                 d;
    logic                  err_c;
    logic [LANES*AW-1:0]   reg_c;
    logic [LANES*MW-1:0]   mem_c;
    logic [TLANES*TW-1:0]  tw_c;
    logic [LP_W-1:0]       p_q;
    logic [2:0]            op_q;

    always_comb begin
        d.op      = op_e'(in_op);
        d.log2p   = in_log2p;
        d.q_short = in_q_short;
        d.mod     = in_mod;
        d.stage   = in_stage;
        d.grp     = in_grp;
    end

    fftag_check   u_check (.d(d), .err(err_c));
    fftag_lanes   u_lanes (.d(d), .reg_addr(reg_c), .mem_addr(mem_c));
    fftag_twiddle u_tw    (.d(d), .tw_addr(tw_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_err <= 1'b0;
            out_reg <= '0;
            out_tw  <= '0;
            out_mem <= '0;
            p_q     <= '0;
            op_q    <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_err <= err_c;
                out_reg <= err_c ? '0 : reg_c;
                out_tw  <= err_c ? '0 : tw_c;
                out_mem <= err_c ? '0 : mem_c;
                p_q     <= in_log2p;
                op_q    <= in_op;
            end else begin
                out_err <= 1'b0;
            end
        end
    end

    a_r9_vld_follows: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld);
    a_r9_vld_idle:    assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld);
    a_r8_err_needs_vld: assert property (@(posedge clk) disable iff (rst) out_err |-> out_vld);
    a_r8_err_clears:  assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_reg == '0 && out_tw == '0 && out_mem == '0));
    a_r3_tw_order:    assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_err && op_q == 3'd0) |->
        (out_tw[0 +: TW] <= out_tw[TW +: TW] && out_tw[TW +: TW] <= out_tw[2*TW +: TW]
         && out_tw[2*TW +: TW] <= out_tw[3*TW +: TW]));
    a_r4_tw_range:    assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_err && op_q == 3'd0) |->
        (int'(out_tw[3*TW +: TW]) < (1 << (int'(p_q) - 1))));

    for (genvar s = 0; s < LANES; s++) begin : g_chk
        a_r2_reg_in_range: assert property (@(posedge clk) disable iff (rst)
            (out_vld && !out_err) |-> (int'(out_reg[s*AW +: AW]) < (1 << int'(p_q))));
    end
endmodule

// File: tb/fftag_top_tb.sv
module fftag_top_tb;
    localparam int AWB = 10, TWB = 9, MWB = 20;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_vld;
    logic [2:0]   in_op;
    logic [3:0]   in_log2p;
    logic         in_q_short;
    logic [7:0]   in_mod;
    logic [3:0]   in_stage;
    logic [9:0]   in_grp;
    logic         out_vld, out_err;
    logic [79:0]  out_reg;
    logic [35:0]  out_tw;
    logic [159:0] out_mem;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fftag_top u_dut (.clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_log2p(in_log2p),
        .in_q_short(in_q_short), .in_mod(in_mod), .in_stage(in_stage), .in_grp(in_grp),
        .out_vld(out_vld), .out_err(out_err), .out_reg(out_reg), .out_tw(out_tw), .out_mem(out_mem));

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int mdl_rev(input int v, input int w);
        int r = 0;
        for (int b = 0; b < w; b++) r |= ((v >> (w - 1 - b)) & 1) << b;
        return r;
    endfunction

    // position after the leading bit has been walked down to index p-j
    function automatic int mdl_stage(input int k, input int p, input int j);
        int r = 0;
        for (int b = 0; b < p; b++) begin
            int src;
            if (b == p - j)     src = p - 1;
            else if (b > p - j) src = b - 1;
            else                src = b;
            r |= ((k >> src) & 1) << b;
        end
        return r;
    endfunction

    task automatic run(input int op, input int lp, input int qs, input int md, input int st, input int g);
        bit e;
        int q, P;
        logic [79:0]  er = '0;
        logic [35:0]  et = '0;
        logic [159:0] em = '0;
        string rq;
        e = 0;
        q = 0;
        P = 0;
        if (lp < 3 || lp > 10) e = 1;
        else begin
            P = 1 << lp;
            q = lp - qs;
            if (md < 1 || md > P / 8) e = 1;
            else if (op > 4) e = 1;
            else if (op == 0 && (st < 1 || st > lp)) e = 1;
            else if (op != 0 && g >= (1 << q)) e = 1;
        end
        if (!e) begin
            for (int s = 0; s < 8; s++) begin
                int k = 8 * (md - 1) + s;
                int ra, ma;
                ma = 0;
                case (op)
                    0: ra = mdl_stage(k, lp, st);
                    1, 3: ra = k;
                    default: ra = mdl_stage(k, lp, lp);
                endcase
                case (op)
                    1: ma = g * P + k;
                    2: ma = g * P + mdl_rev(k, lp);
                    3: ma = mdl_rev(k, lp) * (1 << q) + g;
                    4: ma = mdl_rev(k, lp) * (1 << q) + mdl_rev(g, q);
                    default: ma = 0;
                endcase
                er[s*AWB +: AWB] = AWB'(ra);
                em[s*MWB +: MWB] = MWB'(ma);
            end
            if (op == 0)
                for (int c = 0; c < 4; c++) begin
                    int t = 4 * (md - 1) + c;
                    int sp = 1 << (lp - st);
                    et[c*TWB +: TWB] = TWB'((t / sp) * sp);
                end
        end
        @(negedge clk);
        in_vld = 1; in_op = 3'(op); in_log2p = 4'(lp); in_q_short = qs[0];
        in_mod = 8'(md); in_stage = 4'(st); in_grp = 10'(g);
        @(negedge clk);
        in_vld = 0;
        rq = (op == 0) ? "R2" : (op == 1 || op == 3) ? "R5" : "R6";
        if (qs == 1 && op != 0) rq = {rq, "/R7"};
        chk("R9 out_vld", 160'(out_vld), 160'(1));
        chk("R8 out_err", 160'(out_err), 160'(e));
        chk({rq, " out_reg"}, 160'(out_reg), 160'(er));
        chk("R3 out_tw", 160'(out_tw), 160'(et));
        chk({rq, " out_mem"}, 160'(out_mem), 160'(em));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; in_vld = 0; in_op = 0; in_log2p = 0; in_q_short = 0;
        in_mod = 0; in_stage = 0; in_grp = 0;
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", 160'(out_vld), 160'(0));
        chk("R1 err in reset", 160'(out_err), 160'(0));
        rst = 0;
        @(negedge clk);
        chk("R1 vld after reset", 160'(out_vld), 160'(0));
        chk("R1 err after reset", 160'(out_err), 160'(0));

        // R4 directed: P=32 stage 2
        run(0, 5, 0, 1, 2, 0);
        chk("R4 p32 m1", 160'(out_tw), 160'(36'd0));
        run(0, 5, 0, 2, 2, 0);
        chk("R4 p32 m2", 160'(out_tw), 160'(36'd0));
        run(0, 5, 0, 3, 2, 0);
        chk("R4 p32 m3", 160'(out_tw), 160'({4{9'd8}}));
        run(0, 5, 0, 4, 2, 0);
        chk("R4 p32 m4", 160'(out_tw), 160'({4{9'd8}}));

        // exhaustive butterfly sweep, P = 8..64
        for (int lp = 3; lp <= 6; lp++)
            for (int md = 1; md <= (1 << (lp - 3)); md++)
                for (int st = 1; st <= lp; st++)
                    run(0, lp, 0, md, st, 0);

        // random memory and butterfly mix
        for (int it = 0; it < 600; it++) begin
            int lp = 3 + int'($urandom % 4);
            int qs = int'($urandom % 2);
            int md = 1 + int'($urandom % (1 << (lp - 3)));
            int st = 1 + int'($urandom % lp);
            int op = int'($urandom % 5);
            int g  = int'($urandom % (1 << (lp - qs)));
            run(op, lp, qs, md, st, g);
        end

        // largest size corners
        run(0, 10, 0, 128, 10, 0);
        run(0, 10, 0, 1, 1, 0);
        run(4, 10, 1, 128, 1, 511);
        run(3, 10, 0, 77, 1, 1023);

        // R8 error corners
        run(0, 4, 0, 0, 1, 0);
        run(0, 4, 0, 3, 1, 0);
        run(0, 4, 0, 1, 0, 0);
        run(0, 4, 0, 1, 5, 0);
        run(7, 4, 0, 1, 1, 0);
        run(0, 2, 0, 1, 1, 0);
        run(0, 11, 0, 1, 1, 0);
        run(1, 4, 1, 1, 1, 8);
        run(2, 4, 0, 1, 1, 16);
        run(1, 4, 1, 1, 1, 7);

        // R9 idle cycle
        @(negedge clk);
        chk("R9 idle vld", 160'(out_vld), 160'(0));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule